// File: doc/BRIEF.md
# Dual Programmable Clock Divider

This block derives two gated, divided clock waveforms, one for a processing core and one for a serial link, from a fast source and an alternate bypass source. Both sources arrive as level signals and are sampled by the system clock `clk`. Each derived output is therefore a registered waveform in the `clk` domain. A single 16-bit configuration word, loaded through a write strobe, controls the two outputs. For each output it sets an enable, a source select and a power-of-two divide ratio. A 4-bit frequency setting rides along in the word and is only stored and presented.

Each output uses a free-running counter of source rising edges. When the divide ratio is above one, one bit of that counter produces a waveform with 50% duty. When the ratio is one, the sampled source passes straight through. A new setting never cuts off a high pulse in progress. It is taken over only at a cycle in which the output is low and will stay low, and at that moment the counter is cleared.

Top module: `dual_clk_div`

## Requirements
- R1: After reset both outputs are low, both error flags are 0 and the frequency output is 0. Reset leaves both outputs disabled, on the fast source, at divide by 1.
- R2: Config bit 0 enables the core output and bit 1 enables the link output. A disabled output stays low, and enabling one output has no effect on the other.
- R3: Config bit 2 (core) and bit 3 (link) select the bypass source when 1 and the fast source when 0.
- R4: Config bits 7:4 hold the core divide code n. A code from 0 to 7 gives an output period of 2^n source periods, and code 0 passes the sampled source through.
- R5: Config bits 11:8 hold the link divide code, with the same encoding as the core code.
- R6: For n from 1 to 7 the output is high for 2^(n-1) source periods and low for 2^(n-1) source periods.
- R7: A divide code with bit 3 set is reserved and acts as divide by 1. It sets the error flag for that output (err bit 0 for core, bit 1 for link). The flag holds until the next configuration write, which sets it again only if that write also carries a reserved code.
- R8: Config bits 15:12 appear on the frequency output one cycle after the write and have no effect on either waveform.
- R9: A setting change is applied only while the output is low, so a high pulse under way always completes at its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| fast_src | input | 1 | Fast source clock level |
| byp_src | input | 1 | Bypass source clock level |
| core_clk_o | output | 1 | Gated, divided core clock |
| link_clk_o | output | 1 | Gated, divided link clock |
| freq_o | output | 4 | Stored frequency setting |
| cfg_err_o | output | 2 | Reserved-code flags (bit 0 core, bit 1 link) |

## Verification
The case where two functions meet in one cycle is a configuration write that lands while an output is in the middle of a long high pulse. A divide change then competes with a waveform that is still running. The bench starts a divide-by-16 core waveform, watches for its rising edge, and writes divide by 1 during the high phase. The high pulse must still last its full 32 sample cycles before the new ratio appears. A second overlap occurs when a reserved code and a source select change arrive in the same write. That case is judged by the error flag together with the pass-through period of the newly selected source.

// File: rtl/dclk_pkg.sv
// Shared types and decode helpers for the dual clock divider.
// Assumes the 16-bit configuration layout listed in the brief.
package dclk_pkg;

    localparam int CFG_W   = 16;
    localparam int CODE_W  = 4;
    localparam int MAX_LG  = 7;
    localparam int LG_W    = $clog2(MAX_LG + 1);
    localparam int N_CHAN  = 2;

    // Configuration word, MSB first
    typedef struct packed {
        logic [3:0]        freq;
        logic [CODE_W-1:0] link_div;
        logic [CODE_W-1:0] core_div;
        logic              link_byp;
        logic              core_byp;
        logic              link_en;
        logic              core_en;
    } cfg_word_t;

    // Per-output working setting
    typedef struct packed {
        logic            en;
        logic            byp;
        logic [LG_W-1:0] lg;
    } chan_set_t;

    // Reserved codes have the top bit set
    function automatic logic code_reserved(input logic [CODE_W-1:0] code);
        return code[CODE_W-1];
    endfunction

    // Reserved codes fall back to divide by 1 (log2 = 0)
    function automatic logic [LG_W-1:0] code_to_lg(input logic [CODE_W-1:0] code);
        return code[CODE_W-1] ? '0 : code[LG_W-1:0];
    endfunction

endpackage

// File: rtl/dclk_cfg_reg.sv
// Configuration holding register with sticky reserved-code flags.
// Assumes writes arrive as single-cycle strobes in the clk domain.
module dclk_cfg_reg
    import dclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    output cfg_word_t         cfg,
    output logic [N_CHAN-1:0] err
);

    cfg_word_t wr_word;
    assign wr_word = cfg_word_t'(wr_data);

    // Store the configuration word and capture reserved-code flags on each write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            err <= '0;
        end else if (wr_en) begin
            cfg    <= wr_word;
            err[0] <= code_reserved(wr_word.core_div);
            err[1] <= code_reserved(wr_word.link_div);
        end
    end

    // R7: flags change only through a write
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(err));

    // R8: the frequency field is loaded from the written word
    a_r8_freq_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg.freq == $past(wr_data[15:12])));

endmodule

// File: rtl/dclk_chan.sv
// One divided, gated output. It counts rising edges of the selected source,
// picks a counter bit for a 50% duty result, and takes over a requested
// setting only when its output is low and will stay low.
// Assumes each source stays low for at least two clk samples per period.
module dclk_chan
    import dclk_pkg::*;
#(
    parameter int CNT_W = MAX_LG
)
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_set_t want,
    input  logic      fast_lvl,
    input  logic      fast_rise,
    input  logic      byp_lvl,
    input  logic      byp_rise,
    output logic      clk_o
);

    chan_set_t        act;
    logic [CNT_W-1:0] cnt;
    logic             src_lvl;
    logic             src_rise;
    logic             raw;
    logic             out_d;
    logic             load;

    // Pick the active source level and edge
    always_comb begin
        src_lvl  = act.byp ? byp_lvl  : fast_lvl;
        src_rise = act.byp ? byp_rise : fast_rise;
    end

    // Select pass-through or the counter bit for the active ratio
    always_comb begin
        raw = src_lvl;
        for (int k = 1; k <= CNT_W; k++) begin
            if (act.lg == LG_W'(k)) raw = cnt[k-1];
        end
    end

    // Gate by enable, and allow a setting change only inside a low phase
    always_comb begin
        out_d = act.en & raw;
        load  = !clk_o && !out_d && (want != act);
    end

    // Register the output, the active setting and the edge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= '0;
            cnt   <= '0;
            clk_o <= 1'b0;
        end else begin
            clk_o <= out_d;
            if (load) begin
                act <= want;
                cnt <= '0;
            end else if (src_rise) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R9: the setting is frozen while the output is high
    a_r9_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        clk_o |=> $stable(act));

    // R2: a disabled output drives low on the next cycle
    a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !act.en |=> !clk_o);

    // R4: the counter moves only on a source rising edge or a reload
    a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !src_rise) |=> $stable(cnt));

endmodule

// File: rtl/dual_clk_div.sv
// Top level: configuration register, source edge sampling and two output
// channels. Assumes both source inputs are slow enough relative to clk.
module dual_clk_div
    import dclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    input  logic        fast_src,
    input  logic        byp_src,
    output logic        core_clk_o,
    output logic        link_clk_o,
    output logic [3:0]  freq_o,
    output logic [1:0]  cfg_err_o
);

    cfg_word_t         cfg;
    logic              fast_q, fast_qq, byp_q, byp_qq;
    logic              fast_rise, byp_rise;
    chan_set_t         want [N_CHAN];
    logic [N_CHAN-1:0] chan_out;

    dclk_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg     (cfg),
        .err     (cfg_err_o)
    );

    // Sample both sources and keep one older copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q  <= 1'b0;
            fast_qq <= 1'b0;
            byp_q   <= 1'b0;
            byp_qq  <= 1'b0;
        end else begin
            fast_q  <= fast_src;
            fast_qq <= fast_q;
            byp_q   <= byp_src;
            byp_qq  <= byp_q;
        end
    end

    assign fast_rise = fast_q & ~fast_qq;
    assign byp_rise  = byp_q  & ~byp_qq;

    // Unpack the requested per-output settings
    always_comb begin
        want[0] = '{en: cfg.core_en, byp: cfg.core_byp, lg: code_to_lg(cfg.core_div)};
        want[1] = '{en: cfg.link_en, byp: cfg.link_byp, lg: code_to_lg(cfg.link_div)};
    end

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        dclk_chan #(.CNT_W(MAX_LG)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .want      (want[g]),
            .fast_lvl  (fast_q),
            .fast_rise (fast_rise),
            .byp_lvl   (byp_q),
            .byp_rise  (byp_rise),
            .clk_o     (chan_out[g])
        );
    end

    assign core_clk_o = chan_out[0];
    assign link_clk_o = chan_out[1];
    assign freq_o     = cfg.freq;

endmodule

// File: tb/dual_clk_div_test.sv
module dual_clk_div_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        fast_src = 1'b0;
    logic        byp_src = 1'b0;
    logic        core_clk_o, link_clk_o;
    logic [3:0]  freq_o;
    logic [1:0]  cfg_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dual_clk_div uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .fast_src(fast_src), .byp_src(byp_src), .core_clk_o(core_clk_o),
        .link_clk_o(link_clk_o), .freq_o(freq_o), .cfg_err_o(cfg_err_o)
    );

    // Sources: fast period 4 clk cycles, bypass period 6 clk cycles
    int fcnt = 0, bcnt = 0;
    always @(negedge clk) begin
        fcnt <= (fcnt == 1) ? 0 : fcnt + 1;
        bcnt <= (bcnt == 2) ? 0 : bcnt + 1;
        if (fcnt == 1) fast_src <= ~fast_src;
        if (bcnt == 2) byp_src  <= ~byp_src;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int fr, input int ld, input int cd,
                                       input bit lb, input bit cb, input bit le, input bit ce);
        return {4'(fr), 4'(ld), 4'(cd), lb, cb, le, ce};
    endfunction

    task automatic wcfg(input logic [15:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    function automatic logic sig(input int ch);
        return (ch == 0) ? core_clk_o : link_clk_o;
    endfunction

    task automatic wait_lvl(input int ch, input logic v, output bit tmo);
        tmo = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (sig(ch) == v) return;
        end
        tmo = 1;
    endtask

    // Skip two rising edges, then count one high and one low phase
    task automatic meas(input int ch, output int hi, output int lo);
        bit t;
        hi = -1; lo = -1;
        for (int r = 0; r < 3; r++) begin
            wait_lvl(ch, 1'b0, t); if (t) return;
            wait_lvl(ch, 1'b1, t); if (t) return;
        end
        hi = 1; lo = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (sig(ch)) hi++; else break;
        end
        lo = 1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!sig(ch)) lo++; else break;
        end
    endtask

    task automatic t_reset();
        chk(core_clk_o == 0 && link_clk_o == 0, "R1 outputs low", core_clk_o + 2*link_clk_o, 0);
        chk(cfg_err_o == 0, "R1 err flags", cfg_err_o, 0);
        chk(freq_o == 0, "R1 freq", freq_o, 0);
    endtask

    task automatic t_core_fast();
        int hi, lo, seen;
        int codes[4] = '{0, 1, 3, 5};
        foreach (codes[i]) begin
            wcfg(mk(0, 0, codes[i], 0, 0, 0, 1));
            meas(0, hi, lo);
            chk(hi == 2 * (1 << codes[i]), "R4 R6 core high", hi, 2 * (1 << codes[i]));
            chk(lo == 2 * (1 << codes[i]), "R4 R6 core low", lo, 2 * (1 << codes[i]));
        end
        seen = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (link_clk_o) seen++; end
        chk(seen == 0, "R2 link off while core on", seen, 0);
    endtask

    task automatic t_link_byp();
        int hi, lo;
        wcfg(mk(0, 2, 0, 1, 0, 1, 0));
        meas(1, hi, lo);
        chk(hi == 12 && lo == 12, "R3 R5 link bypass div4 high", hi, 12);
        wcfg(mk(0, 0, 0, 1, 0, 1, 0));
        meas(1, hi, lo);
        chk(hi == 3 && lo == 3, "R3 R5 link bypass div1 high", hi, 3);
        wcfg(mk(0, 7, 0, 1, 0, 1, 0));
        meas(1, hi, lo);
        chk(hi == 384, "R5 R6 link div128 high", hi, 384);
        chk(lo == 384, "R5 R6 link div128 low", lo, 384);
    endtask

    task automatic t_core_byp();
        int hi, lo;
        wcfg(mk(0, 0, 3, 0, 1, 0, 1));
        meas(0, hi, lo);
        chk(hi == 24 && lo == 24, "R3 R4 core bypass div8", hi, 24);
    endtask

    task automatic t_reserved();
        int hi, lo;
        wcfg(mk(0, 0, 4'hA, 0, 0, 0, 1));
        @(negedge clk);
        chk(cfg_err_o == 2'b01, "R7 core reserved flag", cfg_err_o, 1);
        meas(0, hi, lo);
        chk(hi == 2 && lo == 2, "R7 reserved acts as div1", hi, 2);
        chk(cfg_err_o == 2'b01, "R7 flag sticky", cfg_err_o, 1);
        wcfg(mk(0, 4'hF, 4'h9, 1, 0, 1, 1));
        @(negedge clk);
        chk(cfg_err_o == 2'b11, "R7 both reserved", cfg_err_o, 3);
        meas(1, hi, lo);
        chk(hi == 3 && lo == 3, "R7 link reserved bypass div1", hi, 3);
        wcfg(mk(0, 1, 1, 0, 0, 1, 1));
        @(negedge clk);
        chk(cfg_err_o == 2'b00, "R7 cleared by valid write", cfg_err_o, 0);
    endtask

    task automatic t_freq();
        int hi, lo;
        wcfg(mk(4'hA, 0, 2, 0, 0, 0, 1));
        chk(freq_o == 4'hA, "R8 freq field", freq_o, 10);
        meas(0, hi, lo);
        chk(hi == 8 && lo == 8, "R8 freq no effect", hi, 8);
        wcfg(mk(4'h5, 0, 2, 0, 0, 0, 1));
        chk(freq_o == 4'h5, "R8 freq rewrite", freq_o, 5);
        meas(0, hi, lo);
        chk(hi == 8 && lo == 8, "R8 freq rewrite no effect", hi, 8);
    endtask

    task automatic t_pulse_guard();
        int hi, lo;
        bit t;
        wcfg(mk(0, 0, 4, 0, 0, 0, 1));
        meas(0, hi, lo);
        wait_lvl(0, 1'b0, t);
        wait_lvl(0, 1'b1, t);
        hi = 1;
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = mk(0, 0, 0, 0, 0, 0, 1);
        if (core_clk_o) hi++;
        @(negedge clk); cfg_we = 1'b0;
        if (core_clk_o) hi++;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (core_clk_o) hi++; else break;
        end
        chk(hi == 32, "R9 high pulse completes", hi, 32);
        meas(0, hi, lo);
        chk(hi == 2 && lo == 2, "R9 new ratio after low", hi, 2);
    endtask

    task automatic t_disable();
        int seen = 0;
        wcfg(mk(0, 3, 3, 0, 0, 1, 1));
        repeat (200) @(negedge clk);
        wcfg(mk(0, 3, 3, 0, 0, 0, 0));
        repeat (100) @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (core_clk_o || link_clk_o) seen++;
        end
        chk(seen == 0, "R2 disabled outputs low", seen, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_core_fast();
        t_link_byp();
        t_core_byp();
        t_reserved();
        t_freq();
        t_pulse_guard();
        t_disable();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule